// File: doc/BRIEF.md
# Hardware Register Read Unit

This block serves unprivileged reads of a small set of hardware registers. A request names a 5-bit hardware register number. The block checks whether the read is allowed under the current privilege state. If it is, the block returns a 64-bit value one cycle later. If it is not, or the number has no register behind it, the block raises a reserved-instruction fault.

The block also owns two pieces of system-control state. The first is a 32-bit read-permission mask, with one bit per hardware register number. The second is a 64-bit per-thread user word. Both are written, and the mask is also read back, through a small system-control register port. The free-running cycle counter and the privilege inputs come from outside the block. Decode of the rest of the instruction, register-file writeback and exception entry are left to the surrounding pipeline.

Control is a three-state machine: ST_IDLE (no response), ST_REPLY (data strobe) and ST_FAULT (fault strobe). On every clock edge the next state is chosen from the current request alone:
- Any state goes to ST_REPLY on a permitted request for a mapped number.
- Any state goes to ST_FAULT on a denied request or an unmapped number.
- Any state goes to ST_IDLE when there is no request.

Top module: `hwr_read_unit`

## Requirements
- R1: After reset the permission mask and the user word are zero, and neither response strobe is asserted.
- R2: A read is granted when `priv_kernel` is 1, or `cop_usable0` is 1, or the mask bit indexed by the register number is 1. Otherwise the response is a fault with `fault_cause` = 10 and no data strobe. Permission is judged before the number is decoded, so a denied read never returns data.
- R3: Granted reads of numbers 0 and 1 return 0.
- R4: A granted read of number 2 returns `cycle_count` zero-extended to 64 bits, as sampled on the clock edge that accepts the request.
- R5: A granted read of number 3 returns 1.
- R6: A granted read of number 29 returns the full 64-bit user word.
- R7: A granted read of any number other than 0, 1, 2, 3 and 29 gives a fault with cause 10.
- R8: A system-control write to register 7, select 0, stores bits 31:30 and 4:0 of `cfg_wdata` in the mask and clears mask bits 29:5. `cfg_rdata` returns the mask zero-extended to 64 bits while `cfg_reg`=7 and `cfg_sel`=0, and returns 0 for any other address.
- R9: A system-control write to register 4, select 2, loads all 64 bits of `cfg_wdata` into the user word. A write to any other address leaves the user word unchanged.
- R10: A request sampled on an edge is answered on the next cycle by exactly one of `rd_valid` and `fault_valid`, for one cycle only. With no request, neither strobe is asserted. `rd_data` is 0 whenever `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| priv_kernel | input | 1 | Current mode is kernel |
| cop_usable0 | input | 1 | System-control coprocessor usable bit |
| cycle_count | input | 32 | Free-running cycle counter value |
| rd_req | input | 1 | Hardware register read request |
| rd_num | input | 5 | Hardware register number |
| cfg_wr | input | 1 | System-control register write strobe |
| cfg_reg | input | 5 | System-control register number |
| cfg_sel | input | 3 | System-control register select |
| cfg_wdata | input | 64 | System-control write data |
| cfg_rdata | output | 64 | System-control read data (mask or 0) |
| rd_valid | output | 1 | Read data strobe |
| rd_data | output | 64 | Read data, 0 when not valid |
| fault_valid | output | 1 | Fault strobe |
| fault_cause | output | 5 | Fault cause, 10 = reserved instruction |

## Verification
Reads are tried in kernel mode, in user mode with the usable bit set, and in user mode with only the mask granting access. This separates the three grant paths from each other and from a denial. Mapped and unmapped numbers are each read with permission present, which separates a permission fault from a decode fault. Reading number 29 in user mode with an all-ones mask shows that the forced-zero mask bits really stay zero. A user-word write with a distinct pattern in each half, and a write to a neighbouring address, tell a full 64-bit load apart from a truncated one or a misdecoded one.

// File: rtl/hwr_pkg.sv
package hwr_pkg;

    localparam int unsigned DATA_W  = 64;
    localparam int unsigned CNT_W   = 32;
    localparam int unsigned NUM_W   = 5;
    localparam int unsigned SEL_W   = 3;
    localparam int unsigned CAUSE_W = 5;
    localparam int unsigned MASK_W  = 1 << NUM_W;

    localparam logic [CAUSE_W-1:0] CAUSE_RESV = CAUSE_W'(10);

    // hardware register numbers with a value behind them
    localparam logic [NUM_W-1:0] HW_CPU_ID = NUM_W'(0);
    localparam logic [NUM_W-1:0] HW_STEP   = NUM_W'(1);
    localparam logic [NUM_W-1:0] HW_CYCLES = NUM_W'(2);
    localparam logic [NUM_W-1:0] HW_RESOL  = NUM_W'(3);
    localparam logic [NUM_W-1:0] HW_UWORD  = NUM_W'(29);

    // system-control addresses
    localparam logic [NUM_W-1:0] CFG_MASK_REG  = NUM_W'(7);
    localparam logic [SEL_W-1:0] CFG_MASK_SEL  = SEL_W'(0);
    localparam logic [NUM_W-1:0] CFG_UWORD_REG = NUM_W'(4);
    localparam logic [SEL_W-1:0] CFG_UWORD_SEL = SEL_W'(2);

    // mask bits that hold state; the rest read as zero
    localparam logic [MASK_W-1:0] MASK_KEEP = 32'hC000_001F;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_REPLY = 2'd1,
        ST_FAULT = 2'd2
    } hwr_state_e;

endpackage

// File: rtl/hwr_cfg_regs.sv
module hwr_cfg_regs
    import hwr_pkg::*;
#(
    parameter int unsigned DW = DATA_W,
    parameter int unsigned MW = MASK_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic [NUM_W-1:0]     cfg_reg,
    input  logic [SEL_W-1:0]     cfg_sel,
    input  logic [DW-1:0]        cfg_wdata,
    output logic [DW-1:0]        cfg_rdata,
    output logic [MW-1:0]        mask_q,
    output logic [DW-1:0]        uword_q
);
    localparam int unsigned PAD_W = DW - MW;

    logic mask_hit;
    logic uword_hit;

    assign mask_hit  = (cfg_reg == CFG_MASK_REG)  && (cfg_sel == CFG_MASK_SEL);
    assign uword_hit = (cfg_reg == CFG_UWORD_REG) && (cfg_sel == CFG_UWORD_SEL);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '0;
            uword_q <= '0;
        end else if (cfg_wr) begin
            if (mask_hit)
                mask_q <= cfg_wdata[MW-1:0] & MASK_KEEP;
            if (uword_hit)
                uword_q <= cfg_wdata;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (mask_hit)
            cfg_rdata = {{PAD_W{1'b0}}, mask_q};
    end

    // user word only moves on its own address
    p_uword_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_wr && uword_hit) |=> $stable(uword_q));

    // mask only moves on its own address
    p_mask_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_wr && mask_hit) |=> $stable(mask_q));

endmodule

// File: rtl/hwr_select.sv
module hwr_select
    import hwr_pkg::*;
#(
    parameter int unsigned DW = DATA_W,
    parameter int unsigned CW = CNT_W,
    parameter int unsigned MW = MASK_W
) (
    input  logic [NUM_W-1:0] num,
    input  logic             priv_kernel,
    input  logic             cop_usable0,
    input  logic [MW-1:0]    mask,
    input  logic [CW-1:0]    cycles,
    input  logic [DW-1:0]    uword,
    output logic             grant,
    output logic             mapped,
    output logic [DW-1:0]    value
);
    localparam int unsigned ZX_W = DW - CW;

    assign grant = priv_kernel || cop_usable0 || mask[num];

    always_comb begin
        mapped = 1'b1;
        value  = '0;
        unique case (num)
            HW_CPU_ID: value = '0;
            HW_STEP:   value = '0;
            HW_CYCLES: value = {{ZX_W{1'b0}}, cycles};
            HW_RESOL:  value = DW'(1);
            HW_UWORD:  value = uword;
            default: begin
                mapped = 1'b0;
                value  = '0;
            end
        endcase
    end

endmodule

// File: rtl/hwr_read_unit.sv
module hwr_read_unit
    import hwr_pkg::*;
#(
    parameter int unsigned DW = DATA_W,
    parameter int unsigned CW = CNT_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 priv_kernel,
    input  logic                 cop_usable0,
    input  logic [CW-1:0]        cycle_count,
    input  logic                 rd_req,
    input  logic [NUM_W-1:0]     rd_num,
    input  logic                 cfg_wr,
    input  logic [NUM_W-1:0]     cfg_reg,
    input  logic [SEL_W-1:0]     cfg_sel,
    input  logic [DW-1:0]        cfg_wdata,
    output logic [DW-1:0]        cfg_rdata,
    output logic                 rd_valid,
    output logic [DW-1:0]        rd_data,
    output logic                 fault_valid,
    output logic [CAUSE_W-1:0]   fault_cause
);
    logic [MASK_W-1:0] mask_q;
    logic [DW-1:0]     uword_q;
    logic              grant;
    logic              mapped;
    logic [DW-1:0]     value;

    hwr_state_e        state_q, state_d;
    logic [DW-1:0]     data_q, data_d;

    hwr_cfg_regs #(.DW(DW), .MW(MASK_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_reg   (cfg_reg),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .mask_q    (mask_q),
        .uword_q   (uword_q)
    );

    hwr_select #(.DW(DW), .CW(CW), .MW(MASK_W)) u_sel (
        .num         (rd_num),
        .priv_kernel (priv_kernel),
        .cop_usable0 (cop_usable0),
        .mask        (mask_q),
        .cycles      (cycle_count),
        .uword       (uword_q),
        .grant       (grant),
        .mapped      (mapped),
        .value       (value)
    );

    // next state: permission first, then the map
    always_comb begin
        state_d = ST_IDLE;
        data_d  = '0;
        if (rd_req) begin
            if (!grant) begin
                state_d = ST_FAULT;
            end else if (!mapped) begin
                state_d = ST_FAULT;
            end else begin
                state_d = ST_REPLY;
                data_d  = value;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            data_q  <= data_d;
        end
    end

    always_comb begin
        rd_valid    = 1'b0;
        rd_data     = '0;
        fault_valid = 1'b0;
        fault_cause = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_REPLY: begin
                rd_valid = 1'b1;
                rd_data  = data_q;
            end
            ST_FAULT: begin
                fault_valid = 1'b1;
                fault_cause = CAUSE_RESV;
            end
            default: ;
        endcase
    end

    p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && fault_valid));

    p_answer_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> (rd_valid || fault_valid));

    p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> (!rd_valid && !fault_valid));

    p_data_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == '0));

    p_deny_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !priv_kernel && !cop_usable0 && !mask_q[rd_num]) |=> fault_valid);

    p_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> (fault_cause == CAUSE_RESV));

endmodule

// File: tb/test_hwr_read_unit.sv
module test_hwr_read_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        priv_kernel;
    logic        cop_usable0;
    logic [31:0] cycle_count;
    logic        rd_req;
    logic [4:0]  rd_num;
    logic        cfg_wr;
    logic [4:0]  cfg_reg;
    logic [2:0]  cfg_sel;
    logic [63:0] cfg_wdata;
    logic [63:0] cfg_rdata;
    logic        rd_valid;
    logic [63:0] rd_data;
    logic        fault_valid;
    logic [4:0]  fault_cause;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    hwr_read_unit i_hwr_read_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .priv_kernel (priv_kernel),
        .cop_usable0 (cop_usable0),
        .cycle_count (cycle_count),
        .rd_req      (rd_req),
        .rd_num      (rd_num),
        .cfg_wr      (cfg_wr),
        .cfg_reg     (cfg_reg),
        .cfg_sel     (cfg_sel),
        .cfg_wdata   (cfg_wdata),
        .cfg_rdata   (cfg_rdata),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data),
        .fault_valid (fault_valid),
        .fault_cause (fault_cause)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_mode(input logic k, input logic u);
        @(negedge clk);
        priv_kernel = k;
        cop_usable0 = u;
    endtask

    task automatic cfg_write(input logic [4:0] r, input logic [2:0] s, input logic [63:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_reg = r; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_reg = 5'd0; cfg_sel = 3'd0; cfg_wdata = '0;
    endtask

    task automatic mask_readback(input string tag, input logic [63:0] exp);
        @(negedge clk);
        cfg_reg = 5'd7; cfg_sel = 3'd0;
        #1;
        check(tag, cfg_rdata, exp);
        cfg_reg = 5'd0;
    endtask

    // one request; checks the response cycle and the cycle after it
    task automatic hw_read(input string tag, input logic [4:0] num,
                           input logic exp_fault, input logic [63:0] exp_data);
        @(negedge clk);
        rd_req = 1'b1; rd_num = num;
        @(negedge clk);
        rd_req = 1'b0;
        check({tag, " valid"}, {63'd0, rd_valid}, {63'd0, !exp_fault});
        check({tag, " fault"}, {63'd0, fault_valid}, {63'd0, exp_fault});
        check({tag, " data"}, rd_data, exp_fault ? 64'd0 : exp_data);
        if (exp_fault)
            check({tag, " cause"}, {59'd0, fault_cause}, 64'd10);
        @(negedge clk);
        check({tag, " R10 strobes drop"}, {62'd0, rd_valid, fault_valid}, 64'd0);
    endtask

    task automatic t_reset;
        check("R1 valid after reset", {63'd0, rd_valid}, 64'd0);
        check("R1 fault after reset", {63'd0, fault_valid}, 64'd0);
        mask_readback("R1 mask after reset", 64'd0);
        set_mode(1'b1, 1'b0);
        hw_read("R1 user word after reset", 5'd29, 1'b0, 64'd0);
    endtask

    task automatic t_kernel_map;
        set_mode(1'b1, 1'b0);
        hw_read("R3 cpu id", 5'd0, 1'b0, 64'd0);
        hw_read("R3 step", 5'd1, 1'b0, 64'd0);
        cycle_count = 32'hDEAD_BEEF;
        hw_read("R4 cycles", 5'd2, 1'b0, 64'h0000_0000_DEAD_BEEF);
        cycle_count = 32'h8000_0001;
        hw_read("R4 cycles msb", 5'd2, 1'b0, 64'h0000_0000_8000_0001);
        hw_read("R5 resolution", 5'd3, 1'b0, 64'd1);
        hw_read("R7 number 5", 5'd5, 1'b1, 64'd0);
        hw_read("R7 number 31", 5'd31, 1'b1, 64'd0);
        hw_read("R7 number 4", 5'd4, 1'b1, 64'd0);
    endtask

    task automatic t_user_word;
        set_mode(1'b1, 1'b0);
        cfg_write(5'd4, 3'd2, 64'h0123_4567_89AB_CDEF);
        hw_read("R6 R9 user word", 5'd29, 1'b0, 64'h0123_4567_89AB_CDEF);
        cfg_write(5'd4, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF);
        cfg_write(5'd5, 3'd2, 64'h1111_2222_3333_4444);
        hw_read("R9 other address ignored", 5'd29, 1'b0, 64'h0123_4567_89AB_CDEF);
    endtask

    task automatic t_mask;
        cfg_write(5'd7, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF);
        mask_readback("R8 writable bits only", 64'h0000_0000_C000_001F);
        cfg_write(5'd7, 3'd1, 64'd0);
        mask_readback("R8 wrong select ignored", 64'h0000_0000_C000_001F);
        @(negedge clk);
        cfg_reg = 5'd4; cfg_sel = 3'd2;
        #1;
        check("R8 other address reads 0", cfg_rdata, 64'd0);
        cfg_reg = 5'd0; cfg_sel = 3'd0;
    endtask

    task automatic t_user_access;
        set_mode(1'b0, 1'b0);
        cfg_write(5'd7, 3'd0, 64'd0);
        cycle_count = 32'h0000_1234;
        hw_read("R2 denied with empty mask", 5'd2, 1'b1, 64'd0);
        cfg_write(5'd7, 3'd0, 64'hFFFF_FFFF);
        hw_read("R2 granted by mask", 5'd2, 1'b0, 64'h1234);
        hw_read("R2 bit 29 never granted", 5'd29, 1'b1, 64'd0);
        hw_read("R7 mask grants but unmapped", 5'd4, 1'b1, 64'd0);
        cfg_write(5'd7, 3'd0, 64'h0000_0004);
        hw_read("R2 mask bit 3 clear", 5'd3, 1'b1, 64'd0);
        hw_read("R2 mask bit 2 set", 5'd2, 1'b0, 64'h1234);
        set_mode(1'b0, 1'b1);
        hw_read("R2 granted by usable bit", 5'd3, 1'b0, 64'd1);
        hw_read("R2 usable bit user word", 5'd29, 1'b0, 64'h0123_4567_89AB_CDEF);
        set_mode(1'b0, 1'b0);
        cfg_write(5'd7, 3'd0, 64'hFFFF_FFFF_0000_0000);
        mask_readback("R8 upper half of source dropped", 64'd0);
    endtask

    task automatic t_back_to_back;
        set_mode(1'b1, 1'b0);
        @(negedge clk);
        rd_req = 1'b1; rd_num = 5'd3;
        @(negedge clk);
        check("R10 first of pair valid", {63'd0, rd_valid}, 64'd1);
        rd_num = 5'd9;
        @(negedge clk);
        rd_req = 1'b0;
        check("R10 second of pair fault", {62'd0, rd_valid, fault_valid}, 64'd1);
        check("R10 data zero on fault", rd_data, 64'd0);
        @(negedge clk);
        check("R10 idle after pair", {62'd0, rd_valid, fault_valid}, 64'd0);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        rst_n = 1'b0; priv_kernel = 1'b0; cop_usable0 = 1'b0;
        cycle_count = '0; rd_req = 1'b0; rd_num = '0;
        cfg_wr = 1'b0; cfg_reg = '0; cfg_sel = '0; cfg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_kernel_map;
        t_user_word;
        t_mask;
        t_user_access;
        t_back_to_back;
        finish_run;
    end

    initial begin
        #400000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run;
    end

endmodule